// File: doc/BRIEF.md
# DRAM Strobe Bank-Select Decoder

This block drives the four row strobes and four column strobes of a DRAM array. The strobes are active low. A three-bit grouping mode and the two bank bits decide which strobes an access uses. The mode can drive all four strobes together, one half selected by the upper bank bit, or a single lane picked by both bank bits. Four per-lane column enables gate each column strobe, so a partial-width write can leave some byte lanes untouched.

The block also runs refresh cycles. A refresh either asserts every row and column strobe, which is a scrubbing refresh, or asserts the row strobes alone. An optional extended-column mode lets the column strobes of an access outlive the row strobes. Each lane then releases when its own enable drops. A scrubbing refresh always ends all strobes together.

A four-state machine sequences the cycles. Every strobe leaves through a register, so the outputs change one clock edge after the inputs that cause the change. Reset is asynchronous and active low.

- IDLE: no strobe is asserted. A refresh request goes to REFRESH and takes priority. Otherwise an access request goes to ACCESS.
- ACCESS: the latched strobe set is driven. When the request drops, the machine goes to CAS_HOLD if extension is on and some enabled lane is still live. Otherwise it goes to IDLE.
- CAS_HOLD: the row strobes are negated and the held column lanes are trimmed by their enables. The machine returns to IDLE when no lane is left.
- REFRESH: the strobes are driven while the refresh request stays high. The machine then returns to IDLE.

Top module: `strb_bank_decoder`

## Requirements
- R1: While reset is asserted, and after it, until a cycle starts, every bit of `ras_n` and `cas_n` is 1 (negated).
- R2: Grouping modes 000 and 100 through 111 assert all four row strobes on an access. Both bank bits are ignored.
- R3: Mode 001 selects a pair by `bank_sel[1]`. The value 0 gives lanes 0 and 1, and the value 1 gives lanes 2 and 3. `bank_sel[0]` is ignored.
- R4: Mode 010 selects the single lane whose index equals `bank_sel`, read as an unsigned number with bit 1 as the most significant bit.
- R5: Mode 011 asserts all four row strobes on an access, the same as mode 000.
- R6: During an access, `cas_n[i]` is low only when lane i is selected and `lane_en[i]` was high at the preceding edge.
- R7: When `ext_cas_en` is 0 and `acc_req` falls, the row and column strobes are negated on the same edge.
- R8: When `ext_cas_en` is 1 and `acc_req` falls, the row strobes are negated. Each enabled column strobe stays low until its own `lane_en` bit falls, and a released lane is not reasserted.
- R9: In modes other than 011, a refresh asserts all row and all column strobes, whatever `lane_en` holds. On the edge after `rfsh_req` falls, all of them are negated, even when `ext_cas_en` is 1.
- R10: In mode 011, a refresh asserts all row strobes and keeps every column strobe negated.
- R11: The grouping mode and the bank bits are captured when an access starts. Changes during the access do not alter which lanes are used.
- R12: From IDLE, a refresh request wins over a simultaneous access request. An access request that arrives during CAS_HOLD waits until IDLE is reached.
- R13: The strobes change on the first rising clock edge that samples the causing inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 3 | Strobe grouping mode |
| ext_cas_en | input | 1 | 1 keeps column strobes alive after the row strobes are negated |
| bank_sel | input | 2 | Bank bits; bit 1 picks the pair, and both bits pick a single lane |
| lane_en | input | 4 | Per-lane column strobe enables, active high |
| acc_req | input | 1 | Access request; an access lasts while it is high |
| rfsh_req | input | 1 | Refresh request; a refresh lasts while it is high |
| ras_n | output | 4 | Row strobes, active low, registered |
| cas_n | output | 4 | Column strobes, active low, registered |

## Verification
The bench targets the following corner cases:
- The bank bits that a mode should ignore are changed. A wrong decoder would narrow an all-lane access, or it would let `bank_sel[0]` split a pair.
- The lane enables are dropped one at a time during an extended hold. A design that releases all lanes together, or that brings back a released lane, shows wrong `cas_n` bits.
- Refresh is tried with extension on and with all enables low. A design that lets extension or the enables reach a scrubbing refresh would leave column strobes asserted or never assert them.
- The mode and bank bits are changed in the middle of an access. A design that does not capture them at the start would switch lanes while the row strobes are held.
- Requests collide, both in IDLE and during CAS_HOLD. A design with the wrong priority would start an access where a refresh was due, or would assert row strobes while a hold is still running.

// File: rtl/strb_pkg.sv
package strb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ACCESS   = 2'd1,
        ST_CAS_HOLD = 2'd2,
        ST_REFRESH  = 2'd3
    } strb_state_e;

    localparam logic [2:0] MODE_ALL      = 3'b000;
    localparam logic [2:0] MODE_PAIR     = 3'b001;
    localparam logic [2:0] MODE_SINGLE   = 3'b010;
    localparam logic [2:0] MODE_RAS_ONLY = 3'b011;

endpackage

// File: rtl/strb_bank_decode.sv
module strb_bank_decode
    import strb_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [2:0]               mode,
    input  logic [$clog2(LANES)-1:0] bank,
    output logic [LANES-1:0]         sel_mask,
    output logic                     ras_only
);
    localparam int BW   = $clog2(LANES);
    localparam int HALF = LANES / 2;

    logic [LANES-1:0] single_mask;
    logic [LANES-1:0] pair_mask;

    // One-hot lane pick: one compare per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_single
        assign single_mask[g] = (bank == BW'(g));
    end

    // Upper bank bit picks the lower or upper half.
    for (genvar g = 0; g < LANES; g++) begin : g_pair
        if (g < HALF) begin : g_lo
            assign pair_mask[g] = ~bank[BW-1];
        end else begin : g_hi
            assign pair_mask[g] = bank[BW-1];
        end
    end

    always_comb begin
        unique case (mode)
            MODE_PAIR:   sel_mask = pair_mask;
            MODE_SINGLE: sel_mask = single_mask;
            default:     sel_mask = '1;
        endcase
    end

    assign ras_only = (mode == MODE_RAS_ONLY);

endmodule

// File: rtl/strb_seq_fsm.sv
module strb_seq_fsm
    import strb_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_req,
    input  logic             rfsh_req,
    input  logic             ext_cas_en,
    input  logic [LANES-1:0] lane_en,
    input  logic [LANES-1:0] entry_mask,
    input  logic             entry_ras_only,
    output logic [LANES-1:0] ras_on,
    output logic [LANES-1:0] cas_on
);
    strb_state_e      state_q, state_d;
    logic [LANES-1:0] sel_q, sel_d;
    logic [LANES-1:0] hold_q, hold_d;
    logic             scrub_q, scrub_d;
    logic [LANES-1:0] live_lanes;

    assign live_lanes = sel_q & lane_en;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
            hold_q  <= '0;
            scrub_q <= 1'b0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
            hold_q  <= hold_d;
            scrub_q <= scrub_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        hold_d  = hold_q;
        scrub_d = scrub_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rfsh_req) begin
                    state_d = ST_REFRESH;
                    scrub_d = ~entry_ras_only;
                end else if (acc_req) begin
                    state_d = ST_ACCESS;
                    sel_d   = entry_mask;
                end
            end
            ST_ACCESS: begin
                if (!acc_req) begin
                    if (ext_cas_en && (live_lanes != '0)) begin
                        state_d = ST_CAS_HOLD;
                        hold_d  = live_lanes;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_CAS_HOLD: begin
                hold_d = hold_q & lane_en;
                if (hold_d == '0) begin
                    state_d = ST_IDLE;
                end
            end
            ST_REFRESH: begin
                if (!rfsh_req) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Strobe values for the coming cycle
    always_comb begin
        ras_on = '0;
        cas_on = '0;
        unique case (state_d)
            ST_ACCESS: begin
                ras_on = sel_d;
                cas_on = sel_d & lane_en;
            end
            ST_CAS_HOLD: cas_on = hold_d;
            ST_REFRESH: begin
                ras_on = '1;
                cas_on = scrub_d ? '1 : '0;
            end
            default: begin
                ras_on = '0;
                cas_on = '0;
            end
        endcase
    end

endmodule

// File: rtl/strb_out_reg.sv
module strb_out_reg #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] ras_on,
    input  logic [LANES-1:0] cas_on,
    output logic [LANES-1:0] ras_n,
    output logic [LANES-1:0] cas_n
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ras_n[g] <= 1'b1;
                cas_n[g] <= 1'b1;
            end else begin
                ras_n[g] <= ~ras_on[g];
                cas_n[g] <= ~cas_on[g];
            end
        end
    end

endmodule

// File: rtl/strb_bank_decoder.sv
module strb_bank_decoder
    import strb_pkg::*;
#(
    parameter int LANES = 4,
    localparam int BW   = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cfg_mode,
    input  logic             ext_cas_en,
    input  logic [BW-1:0]    bank_sel,
    input  logic [LANES-1:0] lane_en,
    input  logic             acc_req,
    input  logic             rfsh_req,
    output logic [LANES-1:0] ras_n,
    output logic [LANES-1:0] cas_n
);
    logic [LANES-1:0] entry_mask;
    logic             entry_ras_only;
    logic [LANES-1:0] ras_on;
    logic [LANES-1:0] cas_on;

    strb_bank_decode #(.LANES(LANES)) u_decode (
        .mode     (cfg_mode),
        .bank     (bank_sel),
        .sel_mask (entry_mask),
        .ras_only (entry_ras_only)
    );

    strb_seq_fsm #(.LANES(LANES)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .acc_req        (acc_req),
        .rfsh_req       (rfsh_req),
        .ext_cas_en     (ext_cas_en),
        .lane_en        (lane_en),
        .entry_mask     (entry_mask),
        .entry_ras_only (entry_ras_only),
        .ras_on         (ras_on),
        .cas_on         (cas_on)
    );

    strb_out_reg #(.LANES(LANES)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .ras_on (ras_on),
        .cas_on (cas_on),
        .ras_n  (ras_n),
        .cas_n  (cas_n)
    );

endmodule

// File: rtl/strb_bank_decoder_chk.sv
module strb_bank_decoder_chk #(
    parameter int LANES = 4,
    localparam int BW   = $clog2(LANES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       cfg_mode,
    input logic             ext_cas_en,
    input logic [BW-1:0]    bank_sel,
    input logic [LANES-1:0] lane_en,
    input logic             acc_req,
    input logic             rfsh_req,
    input logic [LANES-1:0] ras_n,
    input logic [LANES-1:0] cas_n
);
    // R1: strobes are negated while reset is held
    always @(negedge clk) begin
        if (!rst_n) begin
            p_reset_negated_r1: assert ((ras_n == '1) && (cas_n == '1))
                else $error("R1 strobes asserted during reset");
        end
    end

    // R6: while any row strobe is active, column strobes stay inside it
    p_cas_within_ras_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n != '1) |-> ((~cas_n & ras_n) == '0));

    // R6: a column strobe without its enable only happens in a scrubbing refresh
    p_cas_needs_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((~cas_n & ~$past(lane_en)) != '0) |-> (ras_n == '0));

    // R7: without extension, row and column strobes are negated together
    p_neg_together_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(ras_n) != '1) && (ras_n == '1) && !$past(ext_cas_en))
            |-> (cas_n == '1));

    // R8: while row strobes stay negated, no column lane is newly asserted
    p_hold_shrinks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(ras_n) == '1) && (ras_n == '1))
            |-> ((~cas_n & $past(cas_n)) == '0));

endmodule

bind strb_bank_decoder strb_bank_decoder_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/tb_strb_bank_decoder.sv
`timescale 1ns/1ps
module tb_strb_bank_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_mode = '0;
    logic       ext_cas_en = 1'b0;
    logic [1:0] bank_sel = '0;
    logic [3:0] lane_en = '0;
    logic       acc_req = 1'b0;
    logic       rfsh_req = 1'b0;
    logic [3:0] ras_n;
    logic [3:0] cas_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    strb_bank_decoder dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .ext_cas_en(ext_cas_en),
        .bank_sel(bank_sel), .lane_en(lane_en), .acc_req(acc_req),
        .rfsh_req(rfsh_req), .ras_n(ras_n), .cas_n(cas_n)
    );

    // Reference model of the requirements
    int       m_phase;   // 0 quiet, 1 access, 2 column hold, 3 refresh
    bit [3:0] m_lanes;
    bit [3:0] m_keep;
    bit       m_scrub;
    bit [3:0] exp_ras;
    bit [3:0] exp_cas;

    function automatic bit [3:0] lanes_for(input bit [2:0] m, input bit [1:0] b);
        if (m == 3'b001) return b[1] ? 4'b1100 : 4'b0011;   // R3
        if (m == 3'b010) return 4'b0001 << b;               // R4
        return 4'b1111;                                     // R2, R5
    endfunction

    task automatic model_step();
        bit [3:0] live;
        if (m_phase == 0) begin
            if (rfsh_req) begin
                m_phase = 3;
                m_scrub = (cfg_mode != 3'b011);
            end else if (acc_req) begin
                m_phase = 1;
                m_lanes = lanes_for(cfg_mode, bank_sel);
            end
        end else if (m_phase == 1) begin
            if (!acc_req) begin
                live = m_lanes & lane_en;
                if (ext_cas_en && live != 0) begin
                    m_phase = 2;
                    m_keep  = live;
                end else m_phase = 0;
            end
        end else if (m_phase == 2) begin
            m_keep = m_keep & lane_en;
            if (m_keep == 0) m_phase = 0;
        end else begin
            if (!rfsh_req) m_phase = 0;
        end
        exp_ras = (m_phase == 1) ? m_lanes : (m_phase == 3) ? 4'hF : 4'h0;
        case (m_phase)
            1:       exp_cas = m_lanes & lane_en;
            2:       exp_cas = m_keep;
            3:       exp_cas = m_scrub ? 4'hF : 4'h0;
            default: exp_cas = 4'h0;
        endcase
    endtask

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %b expected %b", tag, got, exp);
        end
    endtask

    // Inputs are already set; one edge passes; outputs are compared at the falling edge
    task automatic step(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk({tag, " ras_n"}, ras_n, ~exp_ras);
        chk({tag, " cas_n"}, cas_n, ~exp_cas);
    endtask

    task automatic quiet();
        acc_req = 0; rfsh_req = 0; ext_cas_en = 0; lane_en = 4'h0;
        step("settle");
        step("settle");
    endtask

    initial begin
        #(20 * 60000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_phase = 0; m_lanes = 0; m_keep = 0; m_scrub = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset ras_n", ras_n, 4'hF);
        chk("R1 reset cas_n", cas_n, 4'hF);
        rst_n = 1'b1;
        step("R1 idle after reset");

        // R2 and R13: all-lane mode, bank bits ignored, one-edge latency
        cfg_mode = 3'b000; bank_sel = 2'b10; lane_en = 4'hF; acc_req = 1;
        step("R2 R13 mode000 start");
        bank_sel = 2'b01; step("R2 mode000 bank ignored");
        quiet();
        for (int m = 4; m < 8; m++) begin
            cfg_mode = 3'(m); bank_sel = 2'(m); lane_en = 4'hF; acc_req = 1;
            step("R2 high mode as all");
            quiet();
        end

        // R3: pairs, bank_sel[0] ignored
        for (int b = 0; b < 4; b++) begin
            cfg_mode = 3'b001; bank_sel = 2'(b); lane_en = 4'hF; acc_req = 1;
            step("R3 pair");
            chk("R3 pair literal", ras_n, b[1] ? 4'b0011 : 4'b1100);
            quiet();
        end

        // R4: single lanes
        for (int b = 0; b < 4; b++) begin
            cfg_mode = 3'b010; bank_sel = 2'(b); lane_en = 4'hF; acc_req = 1;
            step("R4 single");
            chk("R4 single literal", ras_n, ~(4'b0001 << b));
            quiet();
        end

        // R5: mode 011 access
        cfg_mode = 3'b011; bank_sel = 2'b11; lane_en = 4'hF; acc_req = 1;
        step("R5 mode011 access");
        quiet();

        // R6: live lane gating
        cfg_mode = 3'b000; lane_en = 4'b0101; acc_req = 1;
        step("R6 lanes 0101");
        lane_en = 4'b1010; step("R6 lanes 1010");
        cfg_mode = 3'b010; bank_sel = 2'b01; lane_en = 4'b1110;
        step("R6 R11 mode change mid access");
        quiet();

        // R7: no extension
        cfg_mode = 3'b000; lane_en = 4'hF; acc_req = 1; ext_cas_en = 0;
        step("R7 access");
        acc_req = 0; step("R7 drop");
        chk("R7 cas negated with ras", cas_n, 4'hF);
        quiet();

        // R8: extension, staggered release
        cfg_mode = 3'b000; lane_en = 4'hF; acc_req = 1; ext_cas_en = 1;
        step("R8 access");
        acc_req = 0; step("R8 hold start");
        chk("R8 hold literal", cas_n, 4'h0);
        lane_en = 4'b1110; step("R8 release lane0");
        lane_en = 4'b1111; step("R8 lane0 stays released");
        acc_req = 1; step("R12 request waits in hold");
        lane_en = 4'b0000; step("R8 all released");
        step("R12 access after hold");
        quiet();

        // R9: scrubbing refresh ignores enables and extension
        cfg_mode = 3'b010; bank_sel = 2'b00; lane_en = 4'h0; ext_cas_en = 1; rfsh_req = 1;
        step("R9 scrub");
        chk("R9 scrub cas literal", cas_n, 4'h0);
        rfsh_req = 0; lane_en = 4'hF; step("R9 scrub end");
        quiet();

        // R10: RAS-only refresh
        cfg_mode = 3'b011; lane_en = 4'hF; rfsh_req = 1;
        step("R10 ras only");
        chk("R10 cas literal", cas_n, 4'hF);
        quiet();

        // R11: bank change mid access
        cfg_mode = 3'b001; bank_sel = 2'b00; lane_en = 4'hF; acc_req = 1;
        step("R11 pair start");
        bank_sel = 2'b10; cfg_mode = 3'b000; step("R11 capture held");
        quiet();

        // R12: refresh wins over a simultaneous access
        cfg_mode = 3'b000; acc_req = 1; rfsh_req = 1; lane_en = 4'h0;
        step("R12 collision");
        quiet();

        // Constrained random mix
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(3) == 0) acc_req = ~acc_req;
            rfsh_req = ($urandom_range(11) == 0) ? ~rfsh_req : rfsh_req;
            cfg_mode   = 3'($urandom_range(7));
            bank_sel   = 2'($urandom_range(3));
            ext_cas_en = 1'($urandom_range(1));
            if ($urandom_range(2) == 0) lane_en = 4'($urandom_range(15));
            step("random R6 R8 R9 R12");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule